// File: doc/BRIEF.md
# Serial Programming-Port Memory Reader

This block is a host-side controller that fetches bytes from a target's program memory through a two-wire serial programming port. One wire is a clock that the host drives. The other is a data wire that both sides share.

A request gives a 22-bit start address and a byte count. The controller first sends six core-instruction frames, which place the address in the target's table pointer. It then issues one table-read-with-post-increment frame per byte. Each byte it collects is offered on an 8-bit valid/ready stream.

Every frame has the same shape: a 4-bit command sent least significant bit first, then 16 payload clocks. In a read frame the data wire turns around partway through the payload. The host drives zeros for the first eight payload clocks. It then holds the clock low for a programmable turnaround time and releases the wire. The target returns the byte, least significant bit first, during the last eight clocks. The host samples each of those bits on the falling clock edge.

Back-pressure works between frames only. Once a byte is captured, the controller holds it on `rd_data` with `rd_valid` high. It starts no new frame, and the programming clock stays low, until the byte is taken with `rd_ready`. A frame that has begun always runs to completion.

The timing is set in system clocks by three parameters, each at least 1:
- `HI_CYC` is the length of the clock-high phase.
- `LO_CYC` is the length of the clock-low phase.
- `TURN_CYC` is the turnaround time.

Top module: `pgm_reader`

## Requirements
- R1: After reset, `busy`, `done`, `rd_valid`, `pclk_o` and `pdat_oe` are all 0.
- R2: A request with a nonzero count begins with exactly six frames that use command 0000. Their 16-bit operands, sent least significant bit first, are, in this order: 0x0E00 OR addr[21:16], 0x6EF8, 0x0E00 OR addr[15:8], 0x6EF7, 0x0E00 OR addr[7:0], 0x6EF6.
- R3: Each byte is read by a frame with command 1001 (bit 0 first on the wire is 1). In that frame the host sends zeros for payload clocks 1 to 8. It captures the target's bits on the falling edges of payload clocks 9 to 16, and the first bit captured becomes bit 0 of the byte.
- R4: After the falling edge of payload clock 8 of a read frame, the clock stays low and the host keeps driving for at least `TURN_CYC` system clocks. Only then is `pdat_oe` dropped. The host never drives while the target drives.
- R5: `pdat_o` changes only while `pclk_o` is high. Each high phase lasts exactly `HI_CYC` system clocks, and each low phase inside a frame lasts at least `LO_CYC`.
- R6: Bytes come out in ascending address order from the start address. The pointer is loaded only once per request, so carries across bit 8 and bit 16 of the address give correct data.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold their values. No frame is in progress and `pclk_o` stays low.
- R8: `pdat_oe` is 0 whenever no frame is in progress. In particular, it is 0 as soon as a read frame ends.
- R9: `done` is a single-cycle pulse, given after the last byte is accepted. `busy` is low while `done` is high and from then on.
- R10: A request with a count of 0 sends no frame, and `done` pulses within 3 cycles of `start`.
- R11: A `start` given while `busy` is high is ignored. The running request finishes with its own address and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a request (sampled when idle) |
| start_addr | input | 22 | First byte address |
| byte_count | input | CNT_W | Number of bytes to read |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| rd_data | output | 8 | Captured byte |
| rd_valid | output | 1 | `rd_data` holds a byte |
| rd_ready | input | 1 | Consumer accepts the byte |
| pclk_o | output | 1 | Programming clock to target |
| pdat_o | output | 1 | Host data toward target |
| pdat_oe | output | 1 | Host drives the data wire when 1 |
| pdat_i | input | 1 | Data wire as seen by host |

## Verification
The assertions check these properties on every cycle:
- The clock stays low and the host keeps driving during the turnaround.
- Outgoing data changes only while the clock is high.
- The data wire is released whenever the frame engine is idle.
- No frame runs while a byte is pending, and the byte holds steady under back-pressure.
- `done` is a single-cycle pulse.

Some behaviour shows only through the bench's target model:
- whether the operands reach the pointer in the right order;
- whether bits are captured in the right order;
- whether the turnaround delay is long enough;
- whether addresses that carry across byte boundaries return the right data;
- whether a `start` given mid-request is ignored.

// File: rtl/pgm_reader_pkg.sv
package pgm_reader_pkg;
  localparam int ADDR_W    = 22;
  localparam int FRAME_B   = 20;  // 4 command + 16 payload
  localparam int RX_FIRST  = 12;  // first frame bit driven by target
  localparam int LOAD_N    = 6;
  localparam logic [3:0] CMD_CORE = 4'b0000;
  localparam logic [3:0] CMD_TRD  = 4'b1001;

  typedef enum logic [1:0] {FE_IDLE, FE_HIGH, FE_LOW, FE_TURN} fe_state_t;
  typedef enum logic [2:0] {SQ_IDLE, SQ_LGO, SQ_LWAIT, SQ_RGO, SQ_RWAIT, SQ_OUT, SQ_DONE} sq_state_t;

  function automatic logic [15:0] load_operand(input logic [2:0] idx, input logic [ADDR_W-1:0] a);
    case (idx)
      3'd0:    load_operand = {8'h0E, 2'b00, a[21:16]};
      3'd1:    load_operand = 16'h6EF8;
      3'd2:    load_operand = {8'h0E, a[15:8]};
      3'd3:    load_operand = 16'h6EF7;
      3'd4:    load_operand = {8'h0E, a[7:0]};
      default: load_operand = 16'h6EF6;
    endcase
  endfunction
endpackage

// File: rtl/pgm_frame_eng.sv
module pgm_frame_eng
  import pgm_reader_pkg::*;
#(
  parameter int HI_CYC   = 4,
  parameter int LO_CYC   = 4,
  parameter int TURN_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [3:0]  cmd,
  input  logic [15:0] operand,
  input  logic        is_rd,
  output logic        busy,
  output logic        fdone,
  output logic [7:0]  rx_byte,
  output logic        pclk_o,
  output logic        pdat_o,
  output logic        pdat_oe,
  input  logic        pdat_i
);
  localparam int MAX_AB = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int MAX_C  = (MAX_AB > TURN_CYC) ? MAX_AB : TURN_CYC;
  localparam int TW     = $clog2(MAX_C + 1);
  localparam logic [TW-1:0] HI_LD = TW'(HI_CYC - 1);
  localparam logic [TW-1:0] LO_LD = TW'(LO_CYC - 1);
  localparam logic [TW-1:0] TU_LD = TW'(TURN_CYC - 1);
  localparam logic [4:0] LAST_B = 5'(FRAME_B - 1);
  localparam logic [4:0] RX_B   = 5'(RX_FIRST);

  fe_state_t         st;
  logic [TW-1:0]     tmr;
  logic [4:0]        bidx;
  logic [FRAME_B-1:0] frame;
  logic              rd_q;
  logic [7:0]        cap;

  assign busy    = (st != FE_IDLE);
  assign rx_byte = cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= FE_IDLE;
      tmr     <= '0;
      bidx    <= '0;
      frame   <= '0;
      rd_q    <= 1'b0;
      cap     <= '0;
      fdone   <= 1'b0;
      pclk_o  <= 1'b0;
      pdat_o  <= 1'b0;
      pdat_oe <= 1'b0;
    end else begin
      fdone <= 1'b0;
      case (st)
        FE_IDLE: if (go) begin
          frame   <= {(is_rd ? 16'h0000 : operand), cmd};
          rd_q    <= is_rd;
          bidx    <= '0;
          pclk_o  <= 1'b1;
          pdat_o  <= cmd[0];
          pdat_oe <= 1'b1;
          tmr     <= HI_LD;
          st      <= FE_HIGH;
        end
        FE_HIGH: begin
          if (tmr == '0) begin
            pclk_o <= 1'b0;
            tmr    <= LO_LD;
            st     <= FE_LOW;
            if (rd_q && bidx >= RX_B) cap <= {pdat_i, cap[7:1]};
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        FE_LOW: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else if (bidx == LAST_B) begin
            st      <= FE_IDLE;
            pdat_oe <= 1'b0;
            fdone   <= 1'b1;
          end else if (rd_q && bidx == RX_B - 5'd1) begin
            tmr <= TU_LD;
            st  <= FE_TURN;
          end else begin
            bidx   <= bidx + 5'd1;
            pclk_o <= 1'b1;
            pdat_o <= frame[bidx + 5'd1];
            tmr    <= HI_LD;
            st     <= FE_HIGH;
          end
        end
        default: begin  // FE_TURN
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            pdat_oe <= 1'b0;
            bidx    <= RX_B;
            pclk_o  <= 1'b1;
            pdat_o  <= 1'b0;
            tmr     <= HI_LD;
            st      <= FE_HIGH;
          end
        end
      endcase
    end
  end

  // R4
  turn_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FE_TURN) |-> (!pclk_o && pdat_oe));
  // R5
  dat_change_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pdat_o) |-> pclk_o);
  // R8
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FE_IDLE) |-> (!pdat_oe && !pclk_o));
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
  import pgm_reader_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              fe_go,
  output logic [3:0]        fe_cmd,
  output logic [15:0]       fe_op,
  output logic              fe_rd,
  input  logic              fe_busy,
  input  logic              fe_done,
  input  logic [7:0]        fe_byte
);
  localparam logic [2:0] LAST_LD = 3'(LOAD_N - 1);

  sq_state_t         st;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left;
  logic [2:0]        idx;

  assign fe_go  = (st == SQ_LGO) || (st == SQ_RGO);
  assign fe_rd  = (st == SQ_RGO);
  assign fe_cmd = fe_rd ? CMD_TRD : CMD_CORE;
  assign fe_op  = load_operand(idx, addr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      addr_q   <= '0;
      left     <= '0;
      idx      <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          addr_q <= start_addr;
          left   <= byte_count;
          idx    <= '0;
          busy   <= 1'b1;
          st     <= (byte_count == '0) ? SQ_DONE : SQ_LGO;
        end
        SQ_LGO:  st <= SQ_LWAIT;
        SQ_LWAIT: if (fe_done) begin
          if (idx == LAST_LD) st <= SQ_RGO;
          else begin
            idx <= idx + 3'd1;
            st  <= SQ_LGO;
          end
        end
        SQ_RGO:  st <= SQ_RWAIT;
        SQ_RWAIT: if (fe_done) begin
          rd_data  <= fe_byte;
          rd_valid <= 1'b1;
          left     <= left - 1'b1;
          st       <= SQ_OUT;
        end
        SQ_OUT: if (rd_ready) begin
          rd_valid <= 1'b0;
          st       <= (left == '0) ? SQ_DONE : SQ_RGO;
        end
        default: begin  // SQ_DONE
          done <= 1'b1;
          busy <= 1'b0;
          st   <= SQ_IDLE;
        end
      endcase
    end
  end

  // R7
  stall_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !fe_busy);
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !rd_valid));
endmodule

// File: rtl/pgm_reader.sv
module pgm_reader
  import pgm_reader_pkg::*;
#(
  parameter int HI_CYC   = 4,
  parameter int LO_CYC   = 4,
  parameter int TURN_CYC = 8,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [21:0]      start_addr,
  input  logic [CNT_W-1:0] byte_count,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             pclk_o,
  output logic             pdat_o,
  output logic             pdat_oe,
  input  logic             pdat_i
);
  logic        fe_go, fe_rd, fe_busy, fe_done;
  logic [3:0]  fe_cmd;
  logic [15:0] fe_op;
  logic [7:0]  fe_byte;

  pgm_seq #(.CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .busy(busy), .done(done), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .fe_go(fe_go), .fe_cmd(fe_cmd),
    .fe_op(fe_op), .fe_rd(fe_rd), .fe_busy(fe_busy), .fe_done(fe_done),
    .fe_byte(fe_byte)
  );

  pgm_frame_eng #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC), .TURN_CYC(TURN_CYC)) eng_i (
    .clk(clk), .rst_n(rst_n), .go(fe_go), .cmd(fe_cmd), .operand(fe_op),
    .is_rd(fe_rd), .busy(fe_busy), .fdone(fe_done), .rx_byte(fe_byte),
    .pclk_o(pclk_o), .pdat_o(pdat_o), .pdat_oe(pdat_oe), .pdat_i(pdat_i)
  );
endmodule

// File: tb/pgm_reader_tb.sv
module pgm_reader_tb_top;
  localparam int HI = 2, LO = 2, TU = 3;

  logic clk = 0, rst_n = 0, start = 0, rd_ready = 0;
  logic [21:0] start_addr = '0;
  logic [15:0] byte_count = '0;
  logic busy, done, rd_valid, pclk_o, pdat_o, pdat_oe, pdat_i;
  logic [7:0] rd_data;
  logic t_drv = 0, t_bit = 0;
  assign pdat_i = t_drv ? t_bit : 1'b1;

  always #5 clk = ~clk;

  pgm_reader #(.HI_CYC(HI), .LO_CYC(LO), .TURN_CYC(TU), .CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .busy(busy), .done(done), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .pclk_o(pclk_o), .pdat_o(pdat_o),
    .pdat_oe(pdat_oe), .pdat_i(pdat_i)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  int ready_mode = 0;
  logic [7:0] expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_f(input logic [21:0] a);
    mem_f = 8'(a[7:0] * 8'd3) ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'hA5;
  endfunction

  always @(posedge clk) cyc++;

  // ready pattern, driven away from the edge
  always @(posedge clk) begin
    #2;
    case (ready_mode)
      0: rd_ready = 1'b1;
      1: rd_ready = ((cyc * 7) % 5) < 2;
      default: rd_ready = (cyc % 9) == 0;
    endcase
  end

  // target model
  int t_nf = 0, core_frames = 0, rise_cyc = 0, fall_cyc = 0, fall11_cyc = 0;
  logic [3:0] t_cmd = '0;
  logic [15:0] t_op = '0;
  logic [21:0] t_ptr = '0;
  logic [7:0] t_w = '0, t_byte = '0;

  always @(posedge pclk_o) begin
    rise_cyc = cyc;
    if (t_nf > 0) chk(cyc - fall_cyc >= LO, "R5 low phase", cyc - fall_cyc, LO);
    if (t_nf >= 12 && t_cmd == 4'b1001) begin
      if (t_nf == 12) chk(cyc - fall11_cyc >= TU, "R4 turnaround", cyc - fall11_cyc, TU);
      t_drv = 1'b1;
      t_bit = t_byte[t_nf - 12];
    end
  end

  always @(negedge pclk_o) begin
    fall_cyc = cyc;
    chk(cyc - rise_cyc == HI, "R5 high phase", cyc - rise_cyc, HI);
    if (t_nf < 4) t_cmd[t_nf] = pdat_o;
    else t_op[t_nf - 4] = pdat_o;
    if (t_cmd == 4'b1001 && t_nf >= 4 && t_nf < 12 && pdat_o !== 1'b0)
      chk(0, "R3 host zeros", pdat_o, 0);
    if (t_nf == 11 && t_cmd == 4'b1001) begin
      t_byte = mem_f(t_ptr);
      t_ptr = t_ptr + 22'd1;
      fall11_cyc = cyc;
    end
    t_nf++;
    if (t_nf == 20) begin
      if (t_cmd == 4'b0000) begin
        core_frames++;
        if (t_op[15:8] == 8'h0E) t_w = t_op[7:0];
        else if (t_op == 16'h6EF8) t_ptr[21:16] = t_w[5:0];
        else if (t_op == 16'h6EF7) t_ptr[15:8] = t_w;
        else if (t_op == 16'h6EF6) t_ptr[7:0] = t_w;
      end
      t_nf = 0;
      t_drv = 1'b0;
    end
  end

  // monitor / scoreboard
  int done_cnt = 0;
  logic pend = 0;
  logic [7:0] pend_d = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        chk(rd_valid === 1'b1, "R7 valid held", rd_valid, 1);
        chk(rd_data === pend_d, "R7 data held", rd_data, pend_d);
      end
      if (rd_valid && pclk_o) chk(0, "R7 clock while pending", pclk_o, 0);
      if (t_drv && pdat_oe) chk(0, "R4 contention", pdat_oe, 0);
      if (!busy && pdat_oe) chk(0, "R8 released when idle", pdat_oe, 0);
      if (done) begin
        done_cnt++;
        if (busy) chk(0, "R9 busy low at done", busy, 0);
      end
      if (rd_valid && rd_ready) begin
        if (expq.size() == 0) chk(0, "R6 unexpected byte", rd_data, 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(rd_data === e, "R3 R6 byte value", rd_data, e);
        end
      end
      pend = rd_valid && !rd_ready;
      pend_d = rd_data;
    end
  end

  task automatic run_txn(input logic [21:0] a, input int n, input int rm, input bit poke);
    int waited;
    @(negedge clk);
    ready_mode = rm;
    core_frames = 0;
    done_cnt = 0;
    for (int i = 0; i < n; i++) expq.push_back(mem_f(22'(a + 22'(i))));
    start_addr = a;
    byte_count = 16'(n);
    start = 1;
    @(negedge clk);
    start = 0;
    waited = 1;
    while (!done) begin
      @(negedge clk);
      waited++;
      if (poke && waited == 40) begin
        start_addr = 22'h2AAAAA;
        byte_count = 16'd9;
        start = 1;  // R11: must be ignored
        @(negedge clk);
        start = 0;
        waited++;
      end
    end
    if (n == 0) chk(waited <= 3, "R10 quick done", waited, 3);
    @(negedge clk);
    @(negedge clk);
    chk(expq.size() == 0, poke ? "R11 bytes of first request" : "R6 all bytes seen", expq.size(), 0);
    chk(core_frames == (n == 0 ? 0 : 6), n == 0 ? "R10 no frames" : "R2 pointer load frames",
        core_frames, n == 0 ? 0 : 6);
    chk(done_cnt == 1, "R9 single done", done_cnt, 1);
    chk(!busy && !pdat_oe && !rd_valid, "R8 R9 idle after", {busy, pdat_oe, rd_valid}, 0);
    expq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cyc, 200000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk({busy, done, rd_valid, pclk_o, pdat_oe} === 5'b0, "R1 reset state",
        {busy, done, rd_valid, pclk_o, pdat_oe}, 0);
    rst_n = 1;
    @(negedge clk);
    run_txn(22'h000010, 3, 0, 0);
    run_txn(22'h00FFFE, 4, 1, 0);
    run_txn(22'h3FFFFF, 1, 0, 0);
    run_txn(22'h123456, 0, 0, 0);
    run_txn(22'h01FFFF, 2, 0, 1);
    run_txn(22'h155555, 5, 2, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule